// File: doc/BRIEF.md
# USB Controller Interrupt Aggregator

This block gathers the per-endpoint and core event pulses of a USB on-the-go controller into one 32-bit source register and raises a single level interrupt line to a CPU. Software reaches the state through a small memory-mapped register file on a simple synchronous read/write bus. The register file holds a raw source register and a mask register. Each of the two has separate set and clear alias addresses, so software never needs a read-modify-write. A read-only view returns the sources that are both pending and enabled. A revision register returns a fixed nonzero value, and a control register provides a soft reset.

The interrupt line is gated by an end-of-interrupt handshake. After the line has gone high, it can fall once the pending sources are acknowledged. It cannot rise again until software writes the end-of-interrupt address. A typical handler reads the masked view, writes the value it read to the source-clear alias, services those events, and then writes end-of-interrupt.

Hardware events always take priority over software clears of the same bit, so no event is lost during an acknowledge.

Top module: `usb_irq_aggr`

## Requirements
- R1: After reset the source and mask registers read zero, the interrupt line is low, and offset 0x00 reads the nonzero revision constant (default 0x0055_0A01).
- R2: Transmit events occupy bits 4:0, receive events occupy bits 12:9, and core events occupy bits 24:16, with the bus-power-request change on bit 24. Bit 8, bits 15:13 and bits 31:25 always read zero and ignore writes.
- R3: Writing to 0x24 (source set) or 0x30 (mask set) sets exactly the bits written as one.
- R4: Writing to 0x28 (source clear) or 0x34 (mask clear) clears exactly the bits written as one. Reads of any set or clear alias return the underlying register.
- R5: Offset 0x38 always reads source AND mask. Writes to it change nothing.
- R6: The line rises on the clock edge after the one that makes a masked source pending. Once it has been high and has fallen, it stays low while new masked sources become pending, until end-of-interrupt is written.
- R7: When a hardware event and a source-clear write hit the same bit in the same cycle, the bit ends set. Other bits of the clear still clear.
- R8: A write to 0x3C (end of interrupt) makes the line high right after that edge if a masked source is pending. If nothing is pending, the line stays low.
- R9: Writing 1 to bit 0 of 0x04 clears source, mask and the line, and re-arms the line. Writing 0 there has no effect, and 0x04 reads zero.
- R10: A write to 0x20 (source) or 0x2C (mask) replaces the whole register with the written value, limited to the implemented bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evTx | input | NUM_TX (5) | Transmit-endpoint event pulses, endpoint 0 first |
| evRx | input | NUM_RX (4) | Receive-endpoint event pulses |
| evCore | input | NUM_CORE (9) | Core event pulses; the top bit is the bus-power-request change |
| busSel | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| irqOut | output | 1 | Level interrupt to the CPU |

## Verification
The bench builds the block with its default widths: five transmit, four receive and nine core events. With these widths every field sits at its fixed position, and bit 8 and the gaps above bits 12 and 24 stay unimplemented. The bench can therefore check both the live bits and the bits that must ignore writes. Because the line's register delay is fixed, the bench can find the exact edge of each rise, of the lockout after an acknowledge, and of the re-arm by end-of-interrupt, and it tests the same-cycle race between an event and a clear directly.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

  localparam int REG_W  = 32;
  localparam int ADDR_W = 8;

  // Register byte offsets
  localparam logic [ADDR_W-1:0] OFS_REV     = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_SRC     = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_SRC_SET = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_SRC_CLR = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_MSK     = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_MSK_SET = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_MSK_CLR = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_MASKED  = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_EOI     = 8'h3C;

  // Strobes sent from control to datapath, at most one per cycle
  typedef struct packed {
    logic srcLoad;
    logic srcSet;
    logic srcClr;
    logic mskLoad;
    logic mskSet;
    logic mskClr;
    logic softRst;
    logic eoi;
  } regStrobe_t;

  function automatic logic [REG_W-1:0] fieldMask(int lsb, int n);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < n; i++) m[lsb+i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import usb_irq_pkg::*;
#(
  parameter int NUM_TX   = 5,
  parameter int TX_LSB   = 0,
  parameter int NUM_RX   = 4,
  parameter int RX_LSB   = 9,
  parameter int NUM_CORE = 9,
  parameter int CORE_LSB = 16,
  parameter logic [REG_W-1:0] REV_ID = 32'h0055_0A01
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          str,
  input  logic [REG_W-1:0]    wdata,
  input  logic [NUM_TX-1:0]   evTx,
  input  logic [NUM_RX-1:0]   evRx,
  input  logic [NUM_CORE-1:0] evCore,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [REG_W-1:0]    rdata,
  output logic                anyPending
);

  localparam logic [REG_W-1:0] LIVE =
    fieldMask(TX_LSB, NUM_TX) | fieldMask(RX_LSB, NUM_RX) | fieldMask(CORE_LSB, NUM_CORE);

  logic [REG_W-1:0] hwVec;
  logic [REG_W-1:0] srcQ;
  logic [REG_W-1:0] mskQ;
  logic [REG_W-1:0] maskedSrc;

  // Place the event pulses at their field positions
  always_comb begin
    hwVec = '0;
    for (int i = 0; i < NUM_TX; i++)   hwVec[TX_LSB+i]   = evTx[i];
    for (int i = 0; i < NUM_RX; i++)   hwVec[RX_LSB+i]   = evRx[i];
    for (int i = 0; i < NUM_CORE; i++) hwVec[CORE_LSB+i] = evCore[i];
  end

  // One cell per bit: only implemented bits get flops
  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (LIVE[b]) begin : g_live
      logic srcBit;
      logic mskBit;

      // A hardware event has priority over every software action except soft reset
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                       srcBit <= 1'b0;
        else if (str.softRst)            srcBit <= 1'b0;
        else if (hwVec[b])               srcBit <= 1'b1;
        else if (str.srcSet && wdata[b]) srcBit <= 1'b1;
        else if (str.srcClr && wdata[b]) srcBit <= 1'b0;
        else if (str.srcLoad)            srcBit <= wdata[b];
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                       mskBit <= 1'b0;
        else if (str.softRst)            mskBit <= 1'b0;
        else if (str.mskSet && wdata[b]) mskBit <= 1'b1;
        else if (str.mskClr && wdata[b]) mskBit <= 1'b0;
        else if (str.mskLoad)            mskBit <= wdata[b];
      end

      assign srcQ[b] = srcBit;
      assign mskQ[b] = mskBit;
    end else begin : g_dead
      assign srcQ[b] = 1'b0;
      assign mskQ[b] = 1'b0;
    end
  end

  assign maskedSrc  = srcQ & mskQ;
  assign anyPending = |maskedSrc;

  always_comb begin
    case (rdAddr)
      OFS_REV:                           rdata = REV_ID;
      OFS_SRC, OFS_SRC_SET, OFS_SRC_CLR: rdata = srcQ;
      OFS_MSK, OFS_MSK_SET, OFS_MSK_CLR: rdata = mskQ;
      OFS_MASKED:                        rdata = maskedSrc;
      default:                           rdata = '0;
    endcase
  end

  // R7: an event is never lost, whatever software writes in the same cycle
  p_hw_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((|hwVec) && !str.softRst) |=> ((srcQ & $past(hwVec)) == $past(hwVec)));

  // R3: set alias raises every implemented bit written as one
  p_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (str.srcSet && !str.softRst) |=> ((srcQ & $past(wdata & LIVE)) == $past(wdata & LIVE)));

  // R4: clear alias drops the written bits unless an event lands on them
  p_clr_r4: assert property (@(posedge clk) disable iff (!rstN)
    (str.srcClr && !str.softRst) |=> ((srcQ & $past(wdata & ~hwVec)) == '0));

  // R9: soft reset empties source and mask
  p_softrst_r9: assert property (@(posedge clk) disable iff (!rstN)
    str.softRst |=> (srcQ == '0 && mskQ == '0));

endmodule

// File: rtl/irq_control.sv
module irq_control
  import usb_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              ctrlBit0,
  input  logic              anyPending,
  output regStrobe_t        str,
  output logic              irqOut
);

  logic irqQ;
  logic lockQ;
  logic lockEff;
  logic irqNext;
  logic lockNext;

  // Address decode into one strobe per write
  always_comb begin
    str = '0;
    if (busSel && busWrite) begin
      case (busAddr)
        OFS_SRC:     str.srcLoad = 1'b1;
        OFS_SRC_SET: str.srcSet  = 1'b1;
        OFS_SRC_CLR: str.srcClr  = 1'b1;
        OFS_MSK:     str.mskLoad = 1'b1;
        OFS_MSK_SET: str.mskSet  = 1'b1;
        OFS_MSK_CLR: str.mskClr  = 1'b1;
        OFS_CTRL:    str.softRst = ctrlBit0;
        OFS_EOI:     str.eoi     = 1'b1;
        default:     ;
      endcase
    end
  end

  // The lock is set once the line has been high; only end-of-interrupt lifts it
  assign lockEff  = lockQ & ~str.eoi;
  assign irqNext  = anyPending & (irqQ | ~lockEff);
  assign lockNext = lockEff | irqQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqQ  <= 1'b0;
      lockQ <= 1'b0;
    end else if (str.softRst) begin
      irqQ  <= 1'b0;
      lockQ <= 1'b0;
    end else begin
      irqQ  <= irqNext;
      lockQ <= lockNext;
    end
  end

  assign irqOut = irqQ;

  // R6: a rising line always follows a pending masked source
  p_rise_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqQ) |-> $past(anyPending));

  // R6: locked and low stays low without end-of-interrupt
  p_locked_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lockQ && !irqQ && !str.eoi) |=> !irqQ);

  // R8: end-of-interrupt with work pending raises the line
  p_eoi_rearm_r8: assert property (@(posedge clk) disable iff (!rstN)
    (str.eoi && anyPending) |=> irqQ);

  // R9: soft reset drops the line
  p_softrst_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    str.softRst |=> !irqQ);

  p_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $countones(str) <= 1);

endmodule

// File: rtl/usb_irq_aggr.sv
module usb_irq_aggr
  import usb_irq_pkg::*;
#(
  parameter int NUM_TX   = 5,
  parameter int NUM_RX   = 4,
  parameter int NUM_CORE = 9,
  parameter logic [31:0] REV_ID = 32'h0055_0A01
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_TX-1:0]   evTx,
  input  logic [NUM_RX-1:0]   evRx,
  input  logic [NUM_CORE-1:0] evCore,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [7:0]          busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic                irqOut
);

  // Fixed field positions; endpoint 0 has no receive bit, so bit 8 stays empty
  localparam int TX_LSB   = 0;
  localparam int RX_LSB   = 9;
  localparam int CORE_LSB = 16;

  regStrobe_t str;
  logic       anyPending;

  irq_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busSel    (busSel),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .ctrlBit0  (busWdata[0]),
    .anyPending(anyPending),
    .str       (str),
    .irqOut    (irqOut)
  );

  irq_datapath #(
    .NUM_TX  (NUM_TX),
    .TX_LSB  (TX_LSB),
    .NUM_RX  (NUM_RX),
    .RX_LSB  (RX_LSB),
    .NUM_CORE(NUM_CORE),
    .CORE_LSB(CORE_LSB),
    .REV_ID  (REV_ID)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .str       (str),
    .wdata     (busWdata),
    .evTx      (evTx),
    .evRx      (evRx),
    .evCore    (evCore),
    .rdAddr    (busAddr),
    .rdata     (busRdata),
    .anyPending(anyPending)
  );

endmodule

// File: tb/sim_usb_irq_aggr.sv
module sim_usb_irq_aggr;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  evTx = '0;
  logic [3:0]  evRx = '0;
  logic [8:0]  evCore = '0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int checks = 0;
  int fails = 0;

  localparam logic [31:0] LIVE = 32'h01FF_1E1F;

  always #4 clk = ~clk;

  usb_irq_aggr u0 (
    .clk(clk), .rstN(rstN), .evTx(evTx), .evRx(evRx), .evCore(evCore),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic pulse(logic [4:0] t, logic [3:0] r, logic [8:0] c);
    @(negedge clk);
    evTx = t; evRx = r; evCore = c;
    @(negedge clk);
    evTx = '0; evRx = '0; evCore = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h20, v); check("R1 source", v, 32'h0);
    rd(8'h2C, v); check("R1 mask", v, 32'h0);
    check("R1 line", {31'b0, irqOut}, 32'h0);
    rd(8'h00, v); check("R1 revision", v, 32'h0055_0A01);
  endtask

  task automatic t_layout();
    logic [31:0] v;
    wr(8'h04, 32'h1);
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h20, v); check("R2 set all, live bits only", v, LIVE);
    wr(8'h28, 32'hFFFF_FFFF);
    pulse(5'h01, 4'h1, 9'h100);
    rd(8'h20, v); check("R2 tx0/rx-first/bus-power positions", v, 32'h0100_0201);
    pulse(5'h10, 4'h8, 9'h001);
    rd(8'h20, v); check("R2 upper tx/rx, lowest core", v, 32'h0101_1211);
  endtask

  task automatic t_alias();
    logic [31:0] v;
    wr(8'h04, 32'h1);
    wr(8'h30, 32'h0000_0013);
    wr(8'h30, 32'h0100_0000);
    rd(8'h2C, v); check("R3 mask set accumulates", v, 32'h0100_0013);
    wr(8'h34, 32'h0000_0003);
    rd(8'h2C, v); check("R4 mask clear only ones", v, 32'h0100_0010);
    rd(8'h30, v); check("R4 mask-set alias reads mask", v, 32'h0100_0010);
    rd(8'h34, v); check("R4 mask-clear alias reads mask", v, 32'h0100_0010);
    wr(8'h24, 32'h0000_0006);
    rd(8'h20, v); check("R3 source set", v, 32'h0000_0006);
    wr(8'h28, 32'h0000_0002);
    rd(8'h24, v); check("R4 source clear, read via set alias", v, 32'h0000_0004);
    rd(8'h28, v); check("R4 read via clear alias", v, 32'h0000_0004);
  endtask

  task automatic t_masked();
    logic [31:0] v;
    wr(8'h04, 32'h1);
    wr(8'h24, 32'h0000_1E05);
    wr(8'h30, 32'h0000_0A04);
    rd(8'h38, v); check("R5 masked view", v, 32'h0000_0A04);
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h38, v); check("R5 masked write ignored", v, 32'h0000_0A04);
    rd(8'h20, v); check("R5 source untouched", v, 32'h0000_1E05);
    rd(8'h2C, v); check("R5 mask untouched", v, 32'h0000_0A04);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    wr(8'h04, 32'h1);
    wr(8'h30, 32'h0000_0001);
    pulse(5'h01, 4'h0, 9'h000);
    check("R6 line not yet high", {31'b0, irqOut}, 32'h0);
    idle(1);
    check("R6 line high one edge later", {31'b0, irqOut}, 32'h1);
    wr(8'h28, 32'h0000_0001);
    idle(1);
    check("R6 line falls after ack", {31'b0, irqOut}, 32'h0);
    pulse(5'h01, 4'h0, 9'h000);
    idle(3);
    check("R6 locked until end of interrupt", {31'b0, irqOut}, 32'h0);
    rd(8'h38, v); check("R6 source pending while locked", v, 32'h1);
    wr(8'h3C, 32'h0);
    check("R8 line re-armed by end of interrupt", {31'b0, irqOut}, 32'h1);
    wr(8'h28, 32'h0000_0001);
    idle(1);
    wr(8'h3C, 32'h0);
    idle(2);
    check("R8 no pending, line stays low", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] v;
    wr(8'h04, 32'h1);
    wr(8'h24, 32'h0000_0003);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = 8'h28; busWdata = 32'h0000_0003;
    evTx = 5'h01;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busWdata = '0; evTx = '0;
    rd(8'h20, v); check("R7 event beats clear", v, 32'h0000_0001);
  endtask

  task automatic t_softrst();
    logic [31:0] v;
    wr(8'h24, 32'h0000_0005);
    wr(8'h30, 32'h0000_0005);
    idle(1);
    check("R9 line high before soft reset", {31'b0, irqOut}, 32'h1);
    wr(8'h04, 32'h0);
    rd(8'h20, v); check("R9 ctrl write of 0 ignored", v, 32'h0000_0005);
    wr(8'h04, 32'h1);
    rd(8'h20, v); check("R9 source cleared", v, 32'h0);
    rd(8'h2C, v); check("R9 mask cleared", v, 32'h0);
    check("R9 line cleared", {31'b0, irqOut}, 32'h0);
    rd(8'h04, v); check("R9 control reads zero", v, 32'h0);
    wr(8'h24, 32'h0000_0002);
    wr(8'h30, 32'h0000_0002);
    idle(1);
    check("R9 re-armed after soft reset", {31'b0, irqOut}, 32'h1);
  endtask

  task automatic t_direct();
    logic [31:0] v;
    wr(8'h04, 32'h1);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, v); check("R10 source load", v, LIVE);
    wr(8'h20, 32'h0000_0103);
    rd(8'h20, v); check("R10 load replaces, R2 bit 8 empty", v, 32'h0000_0003);
    wr(8'h2C, 32'hFE01_E002);
    rd(8'h2C, v); check("R10 mask load limited to live bits", v, 32'h0001_0002);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(1);
    t_reset();
    t_layout();
    t_alias();
    t_masked();
    t_lock();
    t_race();
    t_softrst();
    t_direct();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule